// File: doc/BRIEF.md
# Sixteen-Way Recency-Rank Replacement Unit

This unit keeps the use order of a 16-way set-associative last-level cache and names the way to evict on a miss. Every line carries a 4-bit recency rank. Rank 0 is the line touched most recently and rank 15 is the line left alone longest. Within one set the sixteen ranks are always a permutation of 0..15. Each line also has four spare metadata bits, for a total of 8 bits per line. The unit keeps the spare bits in storage but gives them no meaning.

The cache controller does the tag compare. It then presents one lookup per cycle on a valid/ready handshake: the data address, a hit flag with the way that hit, the access type and the thread number. The unit reads the set's ranks and applies the true-LRU update. It writes the new ranks back in the same cycle. One cycle after acceptance it returns the way touched, which is the victim on a miss, together with the updated rank vector of that set. After reset the unit walks through every set to seed the ranks, and holds `req_ready` low until that walk is done.

Top module: `lru_repl_unit`

## Requirements
- R1: After reset, `req_ready` stays low while the unit seeds all SETS sets, one set per cycle. It then rises and stays high. A set never touched since reset holds rank i in way i.
- R2: A request accepted with `req_hit`=0 produces `resp_valid`=1 on the next cycle. That response has `resp_miss`=1 and `resp_way` equal to the way whose rank was 15.
- R3: After a miss, the victim way holds rank 0 and every other way of the set holds its old rank plus one.
- R4: After a hit on way w with old rank r, way w holds rank 0. Ways with a rank below r gain one, and ways with a rank above r are unchanged. The response has `resp_miss`=0 and `resp_way`=w.
- R5: In every response, `resp_ranks` is a permutation of 0..15. Way i's rank sits in bits [4i+3:4i].
- R6: The set index is address bits [15:6]. Bits [5:0] and bits above 15 do not change which set is used.
- R7: Requests may arrive back to back, one per cycle, including repeated requests to one set. Each request sees the ranks left by the one before it.
- R8: Each response returns the access type (0 fetch, 1 load, 2 store) and the thread number of its request.
- R9: `resp_valid` is high only in the cycle that follows an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup present |
| req_ready | output | 1 | Unit can take a lookup |
| req_addr | input | ADDR_W | Data address of the access |
| req_type | input | 2 | Access type: 0 fetch, 1 load, 2 store |
| req_thread | input | THR_W | Thread number, 0..NCORES-1 |
| req_hit | input | 1 | Tag compare hit |
| req_hit_way | input | 4 | Way that hit |
| resp_valid | output | 1 | Response present |
| resp_miss | output | 1 | Response belongs to a miss |
| resp_way | output | 4 | Victim way on a miss, hit way on a hit |
| resp_ranks | output | WAYS*4 | Ranks of the set after the update |
| resp_type | output | 2 | Echoed access type |
| resp_thread | output | THR_W | Echoed thread number |

## Verification
The hardest states to reach are sets whose permutation has drifted far from the seeded order. In such a set a hit can land on the oldest way, on the newest way, or just after a long run of misses. The bench first drives sixteen misses in a row into one set, which walks the victim through ways 15 down to 0. It then hits both ends of the rank range. After that, a long random mix of hits and misses goes back to back into a few sets, with random offset and upper address bits. A reference rank table in the bench predicts every response.

// File: rtl/lru_pkg.sv
package lru_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_kind_e;

  localparam int unsigned RESET_SYNC_STAGES = 2;
endpackage

// File: rtl/lru_init_seq.sv
module lru_init_seq #(
  parameter int unsigned SETS = 1024,
  localparam int unsigned SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             busy_o,
  output logic [SET_W-1:0] set_o
);
  localparam logic [SET_W-1:0] LAST_SET = SET_W'(SETS - 1);

  logic [SET_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (busy_q) begin
      if (cnt_q == LAST_SET) busy_d = 1'b0;
      else                   cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;
  assign set_o  = cnt_q;
endmodule

// File: rtl/lru_state_ram.sv
module lru_state_ram #(
  parameter int unsigned SETS    = 1024,
  parameter int unsigned WAYS    = 16,
  parameter int unsigned RANK_W  = 4,
  parameter int unsigned SPARE_W = 4,
  localparam int unsigned SET_W  = $clog2(SETS)
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [SET_W-1:0]          waddr,
  input  logic [WAYS*RANK_W-1:0]    wranks,
  input  logic [WAYS*SPARE_W-1:0]   wspare,
  input  logic [SET_W-1:0]          raddr,
  output logic [WAYS*RANK_W-1:0]    rranks,
  output logic [WAYS*SPARE_W-1:0]   rspare
);
  logic [WAYS*RANK_W-1:0]  rank_mem  [SETS];
  logic [WAYS*SPARE_W-1:0] spare_mem [SETS];

  always_ff @(posedge clk) begin
    if (we) begin
      rank_mem[waddr]  <= wranks;
      spare_mem[waddr] <= wspare;
    end
  end

  assign rranks = rank_mem[raddr];
  assign rspare = spare_mem[raddr];
endmodule

// File: rtl/lru_rank_update.sv
module lru_rank_update #(
  parameter int unsigned WAYS   = 16,
  parameter int unsigned RANK_W = 4
) (
  input  logic [WAYS*RANK_W-1:0] ranks_i,
  input  logic                   hit_i,
  input  logic [RANK_W-1:0]      hit_way_i,
  output logic [RANK_W-1:0]      way_o,
  output logic [WAYS*RANK_W-1:0] ranks_o
);
  localparam logic [RANK_W-1:0] OLDEST = RANK_W'(WAYS - 1);

  logic [WAYS-1:0]   is_oldest;
  logic [RANK_W-1:0] victim;
  logic [RANK_W-1:0] tgt_rank;

  for (genvar g = 0; g < WAYS; g++) begin : g_oldest
    assign is_oldest[g] = (ranks_i[g*RANK_W +: RANK_W] == OLDEST);
  end

  always_comb begin
    victim = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (is_oldest[i]) victim = RANK_W'(i);
    end
  end

  assign way_o    = hit_i ? hit_way_i : victim;
  assign tgt_rank = ranks_i[way_o*RANK_W +: RANK_W];

  for (genvar g = 0; g < WAYS; g++) begin : g_age
    logic [RANK_W-1:0] cur;
    assign cur = ranks_i[g*RANK_W +: RANK_W];
    always_comb begin
      if (way_o == RANK_W'(g))  ranks_o[g*RANK_W +: RANK_W] = '0;
      else if (cur < tgt_rank)  ranks_o[g*RANK_W +: RANK_W] = cur + 1'b1;
      else                      ranks_o[g*RANK_W +: RANK_W] = cur;
    end
  end
endmodule

// File: rtl/lru_repl_unit.sv
module lru_repl_unit #(
  parameter int unsigned WAYS       = 16,
  parameter int unsigned SETS       = 1024,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned NCORES     = 4,
  parameter int unsigned SPARE_W    = 4,
  localparam int unsigned RANK_W    = $clog2(WAYS),
  localparam int unsigned SET_W     = $clog2(SETS),
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned THR_W     = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [1:0]             req_type,
  input  logic [THR_W-1:0]       req_thread,
  input  logic                   req_hit,
  input  logic [RANK_W-1:0]      req_hit_way,
  output logic                   resp_valid,
  output logic                   resp_miss,
  output logic [RANK_W-1:0]      resp_way,
  output logic [WAYS*RANK_W-1:0] resp_ranks,
  output logic [1:0]             resp_type,
  output logic [THR_W-1:0]       resp_thread
);
  localparam int unsigned SYNC_N = lru_pkg::RESET_SYNC_STAGES;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  // seeding walk
  logic             init_busy;
  logic [SET_W-1:0] init_set;

  lru_init_seq #(.SETS(SETS)) u_init (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .busy_o (init_busy),
    .set_o  (init_set)
  );

  assign req_ready = ~init_busy;

  logic             accept;
  logic [SET_W-1:0] req_set;
  logic             unused_addr_bits;

  assign accept  = req_valid & req_ready;
  assign req_set = req_addr[OFF_W +: SET_W];
  assign unused_addr_bits = ^{req_addr[OFF_W-1:0], req_addr[ADDR_W-1:OFF_W+SET_W]};

  // per-set state
  logic [WAYS*RANK_W-1:0]  rd_ranks, upd_ranks, seed_ranks, wr_ranks;
  logic [WAYS*SPARE_W-1:0] rd_spare, wr_spare;
  logic [RANK_W-1:0]       upd_way;
  logic                    wr_en;
  logic [SET_W-1:0]        wr_set;

  for (genvar g = 0; g < WAYS; g++) begin : g_seed
    assign seed_ranks[g*RANK_W +: RANK_W] = RANK_W'(g);
  end

  lru_rank_update #(.WAYS(WAYS), .RANK_W(RANK_W)) u_upd (
    .ranks_i   (rd_ranks),
    .hit_i     (req_hit),
    .hit_way_i (req_hit_way),
    .way_o     (upd_way),
    .ranks_o   (upd_ranks)
  );

  always_comb begin
    wr_en    = init_busy | accept;
    wr_set   = init_busy ? init_set : req_set;
    wr_ranks = init_busy ? seed_ranks : upd_ranks;
    wr_spare = init_busy ? '0 : rd_spare;
  end

  lru_state_ram #(
    .SETS(SETS), .WAYS(WAYS), .RANK_W(RANK_W), .SPARE_W(SPARE_W)
  ) u_ram (
    .clk    (clk),
    .we     (wr_en),
    .waddr  (wr_set),
    .wranks (wr_ranks),
    .wspare (wr_spare),
    .raddr  (req_set),
    .rranks (rd_ranks),
    .rspare (rd_spare)
  );

  // response stage
  logic                   vld_q, vld_d;
  logic                   miss_q, miss_d;
  logic [RANK_W-1:0]      way_q, way_d;
  logic [WAYS*RANK_W-1:0] ranks_q, ranks_d;
  logic [1:0]             type_q, type_d;
  logic [THR_W-1:0]       thr_q, thr_d;

  always_comb begin
    vld_d   = accept;
    miss_d  = ~req_hit;
    way_d   = upd_way;
    ranks_d = upd_ranks;
    type_d  = req_type;
    thr_d   = req_thread;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) vld_q <= 1'b0;
    else            vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      miss_q  <= miss_d;
      way_q   <= way_d;
      ranks_q <= ranks_d;
      type_q  <= type_d;
      thr_q   <= thr_d;
    end
  end

  assign resp_valid  = vld_q;
  assign resp_miss   = miss_q;
  assign resp_way    = way_q;
  assign resp_ranks  = ranks_q;
  assign resp_type   = type_q;
  assign resp_thread = thr_q;
endmodule

// File: rtl/lru_repl_chk.sv
module lru_repl_chk #(
  parameter int unsigned WAYS   = 16,
  parameter int unsigned RANK_W = 4,
  parameter int unsigned THR_W  = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   req_hit,
  input logic [RANK_W-1:0]      req_hit_way,
  input logic [1:0]             req_type,
  input logic [THR_W-1:0]       req_thread,
  input logic                   resp_valid,
  input logic                   resp_miss,
  input logic [RANK_W-1:0]      resp_way,
  input logic [WAYS*RANK_W-1:0] resp_ranks,
  input logic [1:0]             resp_type,
  input logic [THR_W-1:0]       resp_thread
);
  logic [WAYS-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < WAYS; i++) seen[resp_ranks[i*RANK_W +: RANK_W]] = 1'b1;
  end

  // R1
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> req_ready);

  // R9
  resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid == $past(req_valid && req_ready));

  // R2
  miss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_hit) |=> resp_miss);

  // R3
  victim_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_miss) |-> (resp_ranks[resp_way*RANK_W +: RANK_W] == '0));

  // R4
  hit_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_hit) |=> (!resp_miss && resp_way == $past(req_hit_way)));

  // R5
  permutation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (&seen));

  // R8
  echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_type == $past(req_type) && resp_thread == $past(req_thread)));
endmodule

bind lru_repl_unit lru_repl_chk #(.WAYS(WAYS), .RANK_W(RANK_W), .THR_W(THR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_hit     (req_hit),
  .req_hit_way (req_hit_way),
  .req_type    (req_type),
  .req_thread  (req_thread),
  .resp_valid  (resp_valid),
  .resp_miss   (resp_miss),
  .resp_way    (resp_way),
  .resp_ranks  (resp_ranks),
  .resp_type   (resp_type),
  .resp_thread (resp_thread)
);

// File: tb/tb_lru_repl_unit.sv
`timescale 1ns/1ps
module tb_lru_repl_unit;
  localparam int WAYS = 16;
  localparam int SETS = 1024;
  localparam int RW   = 4;
  localparam int TW   = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid;
  logic            req_ready;
  logic [31:0]     req_addr;
  logic [1:0]      req_type;
  logic [TW-1:0]   req_thread;
  logic            req_hit;
  logic [RW-1:0]   req_hit_way;
  logic            resp_valid;
  logic            resp_miss;
  logic [RW-1:0]   resp_way;
  logic [WAYS*RW-1:0] resp_ranks;
  logic [1:0]      resp_type;
  logic [TW-1:0]   resp_thread;

  always #10 clk = ~clk;

  lru_repl_unit dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_type(req_type), .req_thread(req_thread), .req_hit(req_hit),
    .req_hit_way(req_hit_way), .resp_valid(resp_valid), .resp_miss(resp_miss),
    .resp_way(resp_way), .resp_ranks(resp_ranks), .resp_type(resp_type),
    .resp_thread(resp_thread)
  );

  typedef struct {
    logic              miss;
    logic [RW-1:0]     way;
    logic [WAYS*RW-1:0] ranks;
    logic [1:0]        typ;
    logic [TW-1:0]     thr;
    int                ph;
  } exp_t;

  exp_t q[$];
  int   ref_rank [SETS][WAYS];
  int   checks = 0;
  int   errors = 0;
  int   phase  = 0;
  bit   mon_on = 0;
  bit   done   = 0;

  function automatic string ph_tag(int p);
    case (p)
      1: return "R1";
      2: return "R2";
      3: return "R4";
      4: return "R6";
      5: return "R7";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(int upper, int set, int off);
    return (32'(upper) << 16) | (32'(set) << 6) | 32'(off);
  endfunction

  task automatic send(logic [31:0] addr, bit hit, int way, int typ, int thr);
    int   set;
    int   tgt;
    int   r;
    exp_t e;
    @(negedge clk);
    set = int'(addr[15:6]);
    tgt = way;
    if (!hit) begin
      for (int i = 0; i < WAYS; i++) if (ref_rank[set][i] == WAYS - 1) tgt = i;
    end
    r = ref_rank[set][tgt];
    for (int i = 0; i < WAYS; i++) begin
      if (i == tgt)                  ref_rank[set][i] = 0;
      else if (ref_rank[set][i] < r) ref_rank[set][i] = ref_rank[set][i] + 1;
    end
    e.miss = !hit;
    e.way  = RW'(tgt);
    for (int i = 0; i < WAYS; i++) e.ranks[i*RW +: RW] = RW'(ref_rank[set][i]);
    e.typ = 2'(typ);
    e.thr = TW'(thr);
    e.ph  = phase;
    q.push_back(e);
    req_valid   = 1'b1;
    req_addr    = addr;
    req_hit     = hit;
    req_hit_way = RW'(way);
    req_type    = 2'(typ);
    req_thread  = TW'(thr);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (mon_on && resp_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R9", 64'(resp_valid), 64'd0);
      end else begin
        exp_t e;
        logic [WAYS-1:0] seen;
        e = q.pop_front();
        chk(resp_miss == e.miss, {"R2/", ph_tag(e.ph)}, 64'(resp_miss), 64'(e.miss));
        chk(resp_way == e.way, {(e.miss ? "R2/" : "R4/"), ph_tag(e.ph)}, 64'(resp_way), 64'(e.way));
        chk(resp_ranks == e.ranks, {(e.miss ? "R3/" : "R4/"), ph_tag(e.ph)}, resp_ranks, e.ranks);
        chk(resp_type == e.typ && resp_thread == e.thr, "R8",
            64'({resp_type, resp_thread}), 64'({e.typ, e.thr}));
        seen = '0;
        for (int i = 0; i < WAYS; i++) seen[resp_ranks[i*RW +: RW]] = 1'b1;
        chk(&seen, "R5", 64'(seen), 64'hFFFF);
      end
    end
  end

  // watchdog
  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int waited;
    int sets_sel [8] = '{3, 5, 9, 12, 100, 1023, 0, 512};
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) ref_rank[s][w] = w;
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_type = '0; req_thread = '0;
    req_hit = 1'b0; req_hit_way = '0;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b0, "R1", 64'(req_ready), 64'd0);
    chk(resp_valid == 1'b0, "R9", 64'(resp_valid), 64'd0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(req_ready == 1'b0, "R1", 64'(req_ready), 64'd0);
    waited = 10;
    while (!req_ready && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    chk(waited >= SETS && waited <= SETS + 8, "R1", 64'(waited), 64'(SETS));
    mon_on = 1'b1;

    // R1: untouched set keeps seeded ranks, first victim is way 15
    phase = 1;
    send(mk_addr(0, 9, 0), 1'b0, 0, 1, 0);
    // R2: sixteen misses walk the victim from way 15 down to way 0
    phase = 2;
    for (int k = 0; k < 16; k++) send(mk_addr(1, 5, k), 1'b0, 0, k % 3, k % 4);
    // R4: hit on the newest way, then on the oldest way
    phase = 3;
    send(mk_addr(0, 5, 8), 1'b1, 0, 1, 1);
    send(mk_addr(0, 5, 8), 1'b1, 15, 2, 2);
    send(mk_addr(0, 5, 8), 1'b1, 7, 0, 3);
    idle(3);
    chk(resp_valid == 1'b0, "R9", 64'(resp_valid), 64'd0);
    // R6: offset and upper bits do not move the set
    phase = 4;
    send(mk_addr(16'hABCD, 12, 63), 1'b0, 0, 1, 0);
    send(mk_addr(16'h0001, 12, 0), 1'b1, 3, 1, 1);
    send(mk_addr(16'hFFFF, 12, 17), 1'b0, 0, 2, 2);
    // R7: random back-to-back mix over a few sets
    phase = 5;
    for (int k = 0; k < 400; k++) begin
      send(mk_addr($urandom % 65536, sets_sel[$urandom % 8], $urandom % 64),
           1'($urandom % 2), $urandom % 16, $urandom % 3, $urandom % 4);
      if (k % 50 == 49) idle(2);
    end
    idle(4);
    chk(q.size() == 0, "R9", 64'(q.size()), 64'd0);
    chk(resp_valid == 1'b0, "R9", 64'(resp_valid), 64'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule